// File: doc/BRIEF.md
# Wake-up Clock Start-up Sequencer

This block decides when the processor may execute after a reset or after a wake from a low-power mode, and which clock drives it. It watches the reset release, a wake strobe, the requested power mode, the kind of primary oscillator fitted, and a strobe that marks each edge of the primary oscillator. From these inputs it drives four outputs: a hold that keeps the processor stopped, a select between the internal RC clock and the primary clock, a flag that says primary start-up is complete, and a request to power the primary oscillator down. It also keeps a small frequency-select field for the internal RC source.

Crystal-type oscillators must run for a fixed number of their own edges before they can be trusted. RC, external-clock and internal-oscillator kinds need no such wait. When early start is enabled, or the clock monitor is enabled, the processor runs at once on the internal clock and moves to the primary clock when the primary has counted out its wait. Every wake runs a fixed settle delay in system-clock cycles before execution resumes. A wake from idle while the primary clock was still running skips the oscillator wait. The primary is shut down if a low-power mode is requested before it became ready.

The state machine has six states: BOOT (the one cycle after reset), XTAL_WAIT (held while crystal edges are counted), RUN_INT (running early on the internal clock while the crystal is counted), RUN_PRI (running on the primary clock), LOWPWR (idle or sleep, held) and SETTLE (held for the fixed wake delay). The transitions are:
- BOOT goes to RUN_PRI, RUN_INT or XTAL_WAIT through a start decision.
- SETTLE goes through the same start decision when its count completes.
- XTAL_WAIT goes to RUN_PRI on the last counted edge.
- RUN_INT goes to LOWPWR on a low-power request (early shutdown), or to RUN_PRI on the last counted edge.
- RUN_PRI goes to LOWPWR on a low-power request.
- LOWPWR goes to SETTLE on a wake.

Top module: `clk_wake_seq`

## Requirements
- R1: With a crystal kind (osc_kind 0 to 3, so osc_kind[2]=0) and both early_run_en and clk_mon_en low, cpu_hold stays high after reset release for the BOOT edge plus WAIT_EDGES rising edges of clk that sample pri_tick=1. It falls on the edge that samples the last tick. At that edge pri_stable and clk_sel rise; clk_sel=1 means primary.
- R2: With a non-crystal kind (osc_kind 4 to 7), cpu_hold falls on the first rising edge after reset release, whatever the enables. clk_sel=1 and pri_stable=1 from that edge on.
- R3: With a crystal kind and early_run_en or clk_mon_en high, cpu_hold falls on the first rising edge after reset release. clk_sel=0 (internal) and pri_stable=0 at that point.
- R4: While running early on the internal clock, the block switches clk_sel to 1 and sets pri_stable after WAIT_EDGES more ticks. cpu_hold stays low throughout.
- R5: A low-power request while running early sets pri_off and cpu_hold, with clk_sel=0. A later wake settles, clears pri_off and runs early again, restarting the full tick count.
- R6: Idle entered from primary running keeps pri_off=0, clk_sel=1 and pri_stable=1. A wake from it applies no oscillator wait: cpu_hold falls on the (SETTLE_CYC+1)-th rising edge, counting the edge that samples wake.
- R7: Sleep entered from primary running sets pri_off and clears pri_stable and clk_sel. A wake from sleep holds for SETTLE_CYC+1 edges counting the wake edge, plus WAIT_EDGES ticks for a crystal kind. It then runs on the primary with pri_off=0.
- R8: A wake strobe while the processor is running has no effect; cpu_hold stays low.
- R9: fsel is 0 after reset. A write (fsel_wr) is taken at a rising edge only while cpu_hold is low, and is visible after that edge. Writes while held are dropped.
- R10: pm_mode encodes 00 run, 01 idle, and 10 or 11 sleep. A non-run value sampled while running raises cpu_hold after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (internal RC domain) |
| rst_n | input | 1 | Active-low reset; release marks the reset source clearing |
| wake | input | 1 | Wake event strobe |
| pm_mode | input | 2 | Requested power mode: 00 run, 01 idle, 1x sleep |
| osc_kind | input | 3 | Primary oscillator kind: 0..3 crystal types, 4..7 RC, external clock, internal |
| pri_tick | input | 1 | One-cycle strobe per primary oscillator edge |
| early_run_en | input | 1 | Enable early execution on the internal clock |
| clk_mon_en | input | 1 | Clock monitor enable; also allows early execution |
| fsel_wr | input | 1 | Write strobe for the internal frequency select |
| fsel_val | input | FSEL_W | Value written to the internal frequency select |
| cpu_hold | output | 1 | Processor held when high |
| clk_sel | output | 1 | 0 internal clock, 1 primary clock |
| pri_stable | output | 1 | Primary start-up complete |
| pri_off | output | 1 | Request to shut the primary oscillator down |
| fsel | output | FSEL_W | Internal RC frequency select, 0 is the lowest |

## Verification
The bench sweeps every oscillator kind against every combination of the two enables. It counts exact hold lengths, so a design that counted system cycles instead of ticks, or that lost the BOOT edge, shows up as an off-by-N release. The pulsed-tick run separates tick counting from cycle counting. Idle wakes from primary running check that the oscillator wait is skipped; a design that always re-ran it would hold WAIT_EDGES cycles too long. Sleep wakes on crystal kinds confirm the wait is re-applied. A low-power request during early running must raise pri_off and force a full recount on wake; a design that kept a stale partial count would hand over early. Writes to fsel during the held phase must be dropped.

// File: rtl/cws_pkg.sv
package cws_pkg;

    typedef enum logic [2:0] {
        ST_BOOT      = 3'd0,
        ST_XTAL_WAIT = 3'd1,
        ST_RUN_INT   = 3'd2,
        ST_RUN_PRI   = 3'd3,
        ST_LOWPWR    = 3'd4,
        ST_SETTLE    = 3'd5
    } cws_state_e;

    localparam logic [1:0] PM_RUN  = 2'b00;
    localparam logic [1:0] PM_IDLE = 2'b01;

    // Crystal kinds occupy codes 0..3, so bit 2 clear means a wait is needed.
    function automatic logic is_crystal(input logic [2:0] kind);
        return ~kind[2];
    endfunction

endpackage

// File: rtl/cws_cnt.sv
module cws_cnt #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic done
);
    localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (clr)
            cnt <= '0;
        else if (inc)
            cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end

    assign done = inc && !clr && (cnt == LAST);

endmodule

// File: rtl/cws_fsel.sv
module cws_fsel #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] val,
    output logic [W-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= '0;
        else if (wr_en)
            q <= val;
    end
endmodule

// File: rtl/clk_wake_seq.sv
module clk_wake_seq
    import cws_pkg::*;
#(
    parameter int WAIT_EDGES = 1024,
    parameter int SETTLE_CYC = 80,
    parameter int FSEL_W     = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wake,
    input  logic [1:0]        pm_mode,
    input  logic [2:0]        osc_kind,
    input  logic              pri_tick,
    input  logic              early_run_en,
    input  logic              clk_mon_en,
    input  logic              fsel_wr,
    input  logic [FSEL_W-1:0] fsel_val,
    output logic              cpu_hold,
    output logic              clk_sel,
    output logic              pri_stable,
    output logic              pri_off,
    output logic [FSEL_W-1:0] fsel
);
    cws_state_e state, state_nx;
    logic       pri_ok, pri_ok_nx;
    logic       off_r, off_nx;

    cws_state_e dec_state;
    logic       dec_ok;
    logic       wait_done, settle_done;
    logic       counting_wait, in_settle;

    assign counting_wait = (state == ST_XTAL_WAIT) || (state == ST_RUN_INT);
    assign in_settle     = (state == ST_SETTLE);

    cws_cnt #(.LIMIT(WAIT_EDGES)) u_wait_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (!counting_wait),
        .inc   (pri_tick && counting_wait),
        .done  (wait_done)
    );

    cws_cnt #(.LIMIT(SETTLE_CYC)) u_settle_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (!in_settle),
        .inc   (in_settle),
        .done  (settle_done)
    );

    cws_fsel #(.W(FSEL_W)) u_fsel (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (fsel_wr && !cpu_hold),
        .val   (fsel_val),
        .q     (fsel)
    );

    // Start decision shared by BOOT and the end of SETTLE.
    always_comb begin
        dec_ok = pri_ok;
        if (!(is_crystal(osc_kind) && !pri_ok)) begin
            dec_state = ST_RUN_PRI;
            dec_ok    = 1'b1;
        end else if (early_run_en || clk_mon_en) begin
            dec_state = ST_RUN_INT;
        end else begin
            dec_state = ST_XTAL_WAIT;
        end
    end

    always_comb begin
        state_nx  = state;
        pri_ok_nx = pri_ok;
        off_nx    = off_r;
        unique case (state)
            ST_BOOT: begin
                state_nx  = dec_state;
                pri_ok_nx = dec_ok;
            end
            ST_XTAL_WAIT: begin
                if (wait_done) begin
                    state_nx  = ST_RUN_PRI;
                    pri_ok_nx = 1'b1;
                end
            end
            ST_RUN_INT: begin
                if (pm_mode != PM_RUN) begin
                    state_nx = ST_LOWPWR;
                    off_nx   = 1'b1;
                end else if (wait_done) begin
                    state_nx  = ST_RUN_PRI;
                    pri_ok_nx = 1'b1;
                end
            end
            ST_RUN_PRI: begin
                if (pm_mode != PM_RUN) begin
                    state_nx = ST_LOWPWR;
                    if (pm_mode != PM_IDLE) begin
                        pri_ok_nx = 1'b0;
                        off_nx    = 1'b1;
                    end
                end
            end
            ST_LOWPWR: begin
                if (wake)
                    state_nx = ST_SETTLE;
            end
            ST_SETTLE: begin
                if (settle_done) begin
                    state_nx  = dec_state;
                    pri_ok_nx = dec_ok;
                    off_nx    = 1'b0;
                end
            end
            default: begin
                state_nx  = ST_BOOT;
                pri_ok_nx = 1'b0;
                off_nx    = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_BOOT;
            pri_ok <= 1'b0;
            off_r  <= 1'b0;
        end else begin
            state  <= state_nx;
            pri_ok <= pri_ok_nx;
            off_r  <= off_nx;
        end
    end

    always_comb begin
        unique case (state)
            ST_RUN_INT, ST_RUN_PRI: cpu_hold = 1'b0;
            default:                cpu_hold = 1'b1;
        endcase
        clk_sel    = pri_ok;
        pri_stable = pri_ok;
        pri_off    = off_r;
    end

endmodule

// File: rtl/cws_chk.sv
module cws_chk #(
    parameter int W = 3
) (
    input logic         clk,
    input logic         rst_n,
    input logic         cpu_hold,
    input logic         clk_sel,
    input logic         pri_stable,
    input logic         pri_off,
    input logic [W-1:0] fsel,
    input logic [1:0]   pm_mode,
    input logic         early_run_en,
    input logic         clk_mon_en
);
    // R1: without early start, a release means the primary is complete
    a_r1_release_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(cpu_hold) && !early_run_en && !clk_mon_en) |-> pri_stable);

    // R4: completion never appears while the processor is held
    a_r4_stable_while_running: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pri_stable) |-> !cpu_hold);

    // R5: a shutdown request implies the internal clock is in use
    a_r5_off_means_internal: assert property (@(posedge clk) disable iff (!rst_n)
        pri_off |-> (!clk_sel && !pri_stable));

    // R6: primary selection persists while run is requested
    a_r6_primary_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_sel && pm_mode == 2'b00) |=> clk_sel);

    // R9: frequency select frozen while held
    a_r9_fsel_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_hold |=> $stable(fsel));
endmodule

bind clk_wake_seq cws_chk #(.W(FSEL_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cpu_hold     (cpu_hold),
    .clk_sel      (clk_sel),
    .pri_stable   (pri_stable),
    .pri_off      (pri_off),
    .fsel         (fsel),
    .pm_mode      (pm_mode),
    .early_run_en (early_run_en),
    .clk_mon_en   (clk_mon_en)
);

// File: tb/tb_clk_wake_seq.sv
`timescale 1ns/1ps
module tb_clk_wake_seq;
    localparam int N  = 16;
    localparam int S  = 5;
    localparam int FW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wake = 1'b0;
    logic [1:0]    pm_mode = 2'b00;
    logic [2:0]    osc_kind = 3'd0;
    logic          pri_tick = 1'b0;
    logic          early_run_en = 1'b0;
    logic          clk_mon_en = 1'b0;
    logic          fsel_wr = 1'b0;
    logic [FW-1:0] fsel_val = '0;
    logic          cpu_hold, clk_sel, pri_stable, pri_off;
    logic [FW-1:0] fsel;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    clk_wake_seq #(.WAIT_EDGES(N), .SETTLE_CYC(S), .FSEL_W(FW)) dut (
        .clk(clk), .rst_n(rst_n), .wake(wake), .pm_mode(pm_mode),
        .osc_kind(osc_kind), .pri_tick(pri_tick),
        .early_run_en(early_run_en), .clk_mon_en(clk_mon_en),
        .fsel_wr(fsel_wr), .fsel_val(fsel_val),
        .cpu_hold(cpu_hold), .clk_sel(clk_sel), .pri_stable(pri_stable),
        .pri_off(pri_off), .fsel(fsel)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic apply_reset(input int kind, input bit er, input bit cm);
        @(negedge clk);
        rst_n = 1'b0; osc_kind = 3'(kind); early_run_en = er; clk_mon_en = cm;
        pm_mode = 2'b00; wake = 1'b0; fsel_wr = 1'b0; pri_tick = 1'b1;
        repeat (3) @(negedge clk);
        chk("R9 reset fsel", int'(fsel), 0);
        chk("R1 reset hold", int'(cpu_hold), 1);
        chk("R1 reset stable", int'(pri_stable), 0);
        rst_n = 1'b1;
    endtask

    task automatic count_hold(output int n);
        n = 0;
        do begin
            @(posedge clk); n++;
            @(negedge clk); wake = 1'b0;
        end while (cpu_hold && n < 2000);
    endtask

    task automatic wake_count(output int n);
        @(negedge clk); wake = 1'b1;
        count_hold(n);
    endtask

    task automatic count_sel(output int n);
        n = 0;
        while (!clk_sel && n < 2000) begin
            @(posedge clk); n++;
            @(negedge clk);
        end
    endtask

    initial begin
        wait (cyc > 150000);
        fails++;
        $display("FAIL watchdog all-reqs actual=%0d expected=%0d", cyc, 150000);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int n, m;
        // Sweep all oscillator kinds against all enable combinations.
        for (int kind = 0; kind < 8; kind++) begin
            for (int en = 0; en < 4; en++) begin
                bit xtal, early;
                xtal  = (kind < 4);
                early = xtal && (en != 0);
                apply_reset(kind, en[0], en[1]);
                count_hold(n);
                if (!xtal)          chk("R2 release cycles", n, 1);
                else if (en != 0)   chk("R3 release cycles", n, 1);
                else                chk("R1 release cycles", n, N + 1);
                chk(early ? "R3 clk_sel" : "R1 R2 clk_sel", int'(clk_sel), early ? 0 : 1);
                chk(early ? "R3 stable" : "R1 R2 stable", int'(pri_stable), early ? 0 : 1);
                if (early) begin
                    count_sel(m);
                    chk("R4 handover ticks", m, N);
                    chk("R4 hold low", int'(cpu_hold), 0);
                    chk("R4 stable", int'(pri_stable), 1);
                end
                if (en == 0) begin
                    // sleep from primary running
                    @(negedge clk); pm_mode = 2'b10;
                    @(negedge clk);
                    chk("R10 sleep hold", int'(cpu_hold), 1);
                    chk("R7 sleep off", int'(pri_off), 1);
                    chk("R7 sleep stable", int'(pri_stable), 0);
                    chk("R7 sleep sel", int'(clk_sel), 0);
                    pm_mode = 2'b00;
                    wake_count(n);
                    chk("R7 sleep wake cycles", n, S + 1 + (xtal ? N : 0));
                    chk("R7 wake sel", int'(clk_sel), 1);
                    chk("R7 wake off", int'(pri_off), 0);
                    // idle from primary running
                    pm_mode = 2'b01;
                    @(negedge clk);
                    chk("R10 idle hold", int'(cpu_hold), 1);
                    chk("R6 idle off", int'(pri_off), 0);
                    chk("R6 idle sel", int'(clk_sel), 1);
                    pm_mode = 2'b00;
                    wake_count(n);
                    chk("R6 idle wake cycles", n, S + 1);
                    chk("R6 wake sel", int'(clk_sel), 1);
                    // wake while running
                    wake = 1'b1;
                    @(negedge clk); wake = 1'b0;
                    for (int k = 0; k < 3; k++) begin
                        chk("R8 wake ignored", int'(cpu_hold), 0);
                        @(negedge clk);
                    end
                end
            end
        end

        // R1 with sparse ticks: only ticks count, not cycles
        apply_reset(3, 1'b0, 1'b0);
        pri_tick = 1'b0;
        repeat (2) @(negedge clk);
        for (int k = 1; k <= N; k++) begin
            pri_tick = 1'b1;
            @(negedge clk);
            pri_tick = 1'b0;
            if (k == N - 1) chk("R1 sparse hold", int'(cpu_hold), 1);
            if (k == N)     chk("R1 sparse release", int'(cpu_hold), 0);
            @(negedge clk);
        end

        // R5 early shutdown from idle, then restart
        apply_reset(2, 1'b1, 1'b0);
        pri_tick = 1'b0;
        count_hold(n);
        chk("R3 early release", n, 1);
        repeat (4) @(negedge clk);
        chk("R5 still internal", int'(clk_sel), 0);
        pm_mode = 2'b01;
        @(negedge clk);
        chk("R5 early hold", int'(cpu_hold), 1);
        chk("R5 early off", int'(pri_off), 1);
        chk("R5 early sel", int'(clk_sel), 0);
        pm_mode = 2'b00; pri_tick = 1'b1;
        wake_count(n);
        chk("R5 wake cycles", n, S + 1);
        chk("R5 wake off", int'(pri_off), 0);
        chk("R5 wake sel", int'(clk_sel), 0);
        count_sel(m);
        chk("R5 recount", m, N);

        // R5 early shutdown from sleep with the clock monitor enabled
        apply_reset(1, 1'b0, 1'b1);
        pri_tick = 1'b0;
        count_hold(n);
        pm_mode = 2'b11;
        @(negedge clk);
        chk("R5 sleep off", int'(pri_off), 1);
        pm_mode = 2'b00;

        // R9 frequency select
        apply_reset(0, 1'b0, 1'b0);
        fsel_wr = 1'b1; fsel_val = 3'd5;
        @(negedge clk); fsel_wr = 1'b0;
        chk("R9 write while held", int'(fsel), 0);
        count_hold(n);
        fsel_wr = 1'b1; fsel_val = 3'd5;
        @(negedge clk); fsel_wr = 1'b0;
        chk("R9 write taken", int'(fsel), 5);
        fsel_wr = 1'b1; fsel_val = 3'd3;
        @(negedge clk); fsel_wr = 1'b0;
        chk("R9 second write", int'(fsel), 3);
        apply_reset(4, 1'b0, 1'b0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule